// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is a test access port driven by a test clock, a mode-select line and a serial data input. A 16-state controller follows the mode-select line on each rising test-clock edge. A 10-bit instruction register chooses which data register sits between the serial input and the serial output.

The data registers are:
- a 1-bit pass-through stage;
- a fixed 32-bit identification word;
- a fixed 32-bit user word;
- a 22-bit boot-address register, whose parallel value leaves the block;
- a short boundary chain with one cell per controlled pin.

The decoded instruction also controls the pins. It can float every controlled output, hold the outputs at the latched boundary pattern, or raise a reconfiguration request.

The serial output changes only on falling test-clock edges, and it carries its own enable. Instructions and data updates take effect on the falling edge of the update states. An optional active-low test reset puts the controller in its reset state asynchronously. Its release is synchronised to the test clock.

Top module: `scan_tap_ctrl`

## Requirements
- R1: After test reset, or after five rising test-clock edges with mode-select high from any state, the controller is in Test-Logic-Reset and the active instruction is the identification instruction (10'h006). A data scan then returns the 32-bit identification word, least significant bit first.
- R2: Capture-IR loads 10'b00_0000_0001 into the instruction shift stage. A new instruction takes effect only on the falling edge of Update-IR, never while the instruction is still being shifted.
- R3: Instruction 10'h006 selects the 32-bit identification word and instruction 10'h007 selects the 32-bit user word. Each is loaded in Capture-DR and shifted out least significant bit first.
- R4: Instruction 10'h3FF, and any code this block does not define, selects a 1-bit pass-through stage. That stage captures 0, so each data bit appears on the serial output one shift later.
- R5: Instruction 10'h005 captures the pin inputs into the boundary chain, with cell 0 first out. It latches the shifted pattern on Update-DR and leaves `pin_out` and `pin_oe` equal to the core values.
- R6: Instruction 10'h00F drives `pin_out` from the latched boundary pattern with every `pin_oe` bit high. It also captures the pin inputs into the chain.
- R7: Instruction 10'h00B selects the pass-through stage, clears every `pin_oe` bit and raises `hiz_o`.
- R8: Instruction 10'h00A selects the pass-through stage, drives `pin_out` from the latched boundary pattern with every `pin_oe` bit high, and raises `clamp_o`. Data scans under this instruction leave the latched pattern unchanged.
- R9: Instruction 10'h270 selects a 22-bit boot-address register. Capture-DR loads the current `boot_addr`, which resets to 0. The shifted value reaches `boot_addr` on the falling edge of Update-DR.
- R10: While instruction 10'h001 is active and the controller is in Run-Test/Idle, `reconfig_req` is high. It is low at all other times.
- R11: `tdo_oe` is high only while the controller is in Shift-IR or Shift-DR. `tdo` changes only on the falling test-clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Optional asynchronous test reset, active low |
| tms | input | 1 | Mode-select line, sampled on the rising edge |
| tdi | input | 1 | Serial data input |
| tdo | output | 1 | Serial data output, updated on the falling edge |
| tdo_oe | output | 1 | Output enable for `tdo` |
| core_out | input | NPIN | Functional output values from the core |
| core_oe | input | NPIN | Functional output enables from the core |
| pin_in | input | NPIN | Pin input values for boundary capture |
| pin_out | output | NPIN | Output values to the pins |
| pin_oe | output | NPIN | Output enables to the pins |
| hiz_o | output | 1 | Float-all-pins instruction is active |
| clamp_o | output | 1 | Hold-pins instruction is active |
| reconfig_req | output | 1 | Reconfiguration request |
| boot_addr | output | BOOT_W | Latched boot address |

## Verification
The test-clock walk of the state register determines every effect, so a wrong state shows at the ports within one scan:
- a missed capture returns a stale word on `tdo`;
- an early or late update moves `pin_out`, `pin_oe` or `boot_addr` one scan too soon or too late;
- a wrong Test-Logic-Reset path leaves a scan after five mode-select-high edges returning something other than the identification word.

Because `tdo` moves on the falling edge, a clock-edge mistake shows as a half-cycle shift. The bench samples `tdo` just after the rising edge and again just after the falling edge, so that shift is visible.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

  localparam int IR_W = 10;

  typedef enum logic [3:0] {
    S_TLR, S_RTI,
    S_SEL_DR, S_CAP_DR, S_SH_DR, S_EX1_DR, S_PAU_DR, S_EX2_DR, S_UPD_DR,
    S_SEL_IR, S_CAP_IR, S_SH_IR, S_EX1_IR, S_PAU_IR, S_EX2_IR, S_UPD_IR
  } tap_state_t;

  typedef enum logic [2:0] {
    DR_PASS, DR_IDENT, DR_USER, DR_CHAIN, DR_BOOT
  } dr_sel_t;

  localparam logic [IR_W-1:0] OP_PASS    = 10'h3FF;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 10'h005;
  localparam logic [IR_W-1:0] OP_EXTEST  = 10'h00F;
  localparam logic [IR_W-1:0] OP_USER    = 10'h007;
  localparam logic [IR_W-1:0] OP_IDENT   = 10'h006;
  localparam logic [IR_W-1:0] OP_FLOAT   = 10'h00B;
  localparam logic [IR_W-1:0] OP_HOLD    = 10'h00A;
  localparam logic [IR_W-1:0] OP_RECONF  = 10'h001;
  localparam logic [IR_W-1:0] OP_BOOT    = 10'h270;
  localparam logic [IR_W-1:0] IR_CAPTURE = 10'h001;

endpackage

// File: rtl/scan_rst_sync.sv
module scan_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic tck,
  input  logic trst_n,
  output logic rst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n = sync_q[STAGES-1];
endmodule

// File: rtl/scan_tap_fsm.sv
module scan_tap_fsm
  import scan_tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_t state
);
  tap_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_TLR:    state_d = tms ? S_TLR    : S_RTI;
      S_RTI:    state_d = tms ? S_SEL_DR : S_RTI;
      S_SEL_DR: state_d = tms ? S_SEL_IR : S_CAP_DR;
      S_CAP_DR: state_d = tms ? S_EX1_DR : S_SH_DR;
      S_SH_DR:  state_d = tms ? S_EX1_DR : S_SH_DR;
      S_EX1_DR: state_d = tms ? S_UPD_DR : S_PAU_DR;
      S_PAU_DR: state_d = tms ? S_EX2_DR : S_PAU_DR;
      S_EX2_DR: state_d = tms ? S_UPD_DR : S_SH_DR;
      S_UPD_DR: state_d = tms ? S_SEL_DR : S_RTI;
      S_SEL_IR: state_d = tms ? S_TLR    : S_CAP_IR;
      S_CAP_IR: state_d = tms ? S_EX1_IR : S_SH_IR;
      S_SH_IR:  state_d = tms ? S_EX1_IR : S_SH_IR;
      S_EX1_IR: state_d = tms ? S_UPD_IR : S_PAU_IR;
      S_PAU_IR: state_d = tms ? S_EX2_IR : S_PAU_IR;
      S_EX2_IR: state_d = tms ? S_UPD_IR : S_SH_IR;
      S_UPD_IR: state_d = tms ? S_SEL_DR : S_RTI;
      default:  state_d = S_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state_q <= S_TLR;
    else        state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/scan_tap_ireg.sv
module scan_tap_ireg
  import scan_tap_pkg::*;
(
  input  logic            tck,
  input  logic            rst_n,
  input  tap_state_t      state,
  input  logic            tdi,
  output logic [IR_W-1:0] ir_act,
  output logic            ir_so,
  output dr_sel_t         dr_sel,
  output logic            float_pins,
  output logic            hold_pins,
  output logic            chain_drive,
  output logic            reconf_sel
);
  logic [IR_W-1:0] sh_q, sh_d;
  logic [IR_W-1:0] act_q, act_d;
  logic            sh_en, act_en;

  // shift stage: rising edge
  assign sh_en = (state == S_CAP_IR) || (state == S_SH_IR);

  always_comb begin
    sh_d = sh_q;
    if (state == S_CAP_IR)     sh_d = IR_CAPTURE;
    else if (state == S_SH_IR) sh_d = {tdi, sh_q[IR_W-1:1]};
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)     sh_q <= IR_CAPTURE;
    else if (sh_en) sh_q <= sh_d;
  end

  // active instruction: falling edge, forced to identification in reset state
  assign act_en = (state == S_UPD_IR) || (state == S_TLR);
  assign act_d  = (state == S_TLR) ? OP_IDENT : sh_q;

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n)      act_q <= OP_IDENT;
    else if (act_en) act_q <= act_d;
  end

  always_comb begin
    dr_sel      = DR_PASS;
    float_pins  = 1'b0;
    hold_pins   = 1'b0;
    chain_drive = 1'b0;
    reconf_sel  = 1'b0;
    case (act_q)
      OP_IDENT:  dr_sel = DR_IDENT;
      OP_USER:   dr_sel = DR_USER;
      OP_SAMPLE: dr_sel = DR_CHAIN;
      OP_EXTEST: begin dr_sel = DR_CHAIN; chain_drive = 1'b1; end
      OP_FLOAT:  float_pins = 1'b1;
      OP_HOLD:   begin hold_pins = 1'b1; chain_drive = 1'b1; end
      OP_BOOT:   dr_sel = DR_BOOT;
      OP_RECONF: reconf_sel = 1'b1;
      default:   dr_sel = DR_PASS;
    endcase
  end

  assign ir_act = act_q;
  assign ir_so  = sh_q[0];
endmodule

// File: rtl/scan_tap_dregs.sv
module scan_tap_dregs
  import scan_tap_pkg::*;
#(
  parameter int          NPIN       = 4,
  parameter int          WORD_W     = 32,
  parameter int          BOOT_W     = 22,
  parameter logic [31:0] ID_VALUE   = 32'h1234_50DD,
  parameter logic [31:0] USER_VALUE = 32'hCAFE_0001
) (
  input  logic              tck,
  input  logic              rst_n,
  input  tap_state_t        state,
  input  dr_sel_t           dr_sel,
  input  logic              tdi,
  input  logic [NPIN-1:0]   pin_in,
  output logic              dr_so,
  output logic [NPIN-1:0]   chain_latch,
  output logic [BOOT_W-1:0] boot_addr
);
  logic cap, shf, upd;
  assign cap = (state == S_CAP_DR);
  assign shf = (state == S_SH_DR);
  assign upd = (state == S_UPD_DR);

  // pass-through stage
  logic pass_q, pass_d, pass_en;
  assign pass_en = (dr_sel == DR_PASS) && (cap || shf);
  assign pass_d  = cap ? 1'b0 : tdi;
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)       pass_q <= 1'b0;
    else if (pass_en) pass_q <= pass_d;
  end

  // identification / user words share one shift stage
  logic [WORD_W-1:0] word_q, word_d;
  logic              word_en, word_sel;
  assign word_sel = (dr_sel == DR_IDENT) || (dr_sel == DR_USER);
  assign word_en  = word_sel && (cap || shf);
  always_comb begin
    if (cap) word_d = (dr_sel == DR_USER) ? USER_VALUE[WORD_W-1:0] : ID_VALUE[WORD_W-1:0];
    else     word_d = {tdi, word_q[WORD_W-1:1]};
  end
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (word_en) word_q <= word_d;
  end

  // boot address: shift stage plus falling-edge latch
  logic [BOOT_W-1:0] boot_sh_q, boot_sh_d, boot_lat_q;
  logic              boot_sh_en, boot_up_en;
  assign boot_sh_en = (dr_sel == DR_BOOT) && (cap || shf);
  assign boot_up_en = (dr_sel == DR_BOOT) && upd;
  assign boot_sh_d  = cap ? boot_lat_q : {tdi, boot_sh_q[BOOT_W-1:1]};
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)          boot_sh_q <= '0;
    else if (boot_sh_en) boot_sh_q <= boot_sh_d;
  end
  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n)          boot_lat_q <= '0;
    else if (boot_up_en) boot_lat_q <= boot_sh_q;
  end
  assign boot_addr = boot_lat_q;

  // boundary chain: one capture/shift cell and one latch per pin
  logic [NPIN-1:0] cell_q, cell_lat_q;
  logic            chain_sh_en, chain_up_en;
  assign chain_sh_en = (dr_sel == DR_CHAIN) && (cap || shf);
  assign chain_up_en = (dr_sel == DR_CHAIN) && upd;

  for (genvar i = 0; i < NPIN; i++) begin : g_cell
    logic ser_in, cell_d;
    if (i == NPIN - 1) begin : g_head
      assign ser_in = tdi;
    end else begin : g_link
      assign ser_in = cell_q[i+1];
    end
    assign cell_d = cap ? pin_in[i] : ser_in;
    always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)           cell_q[i] <= 1'b0;
      else if (chain_sh_en) cell_q[i] <= cell_d;
    end
    always_ff @(negedge tck or negedge rst_n) begin
      if (!rst_n)           cell_lat_q[i] <= 1'b0;
      else if (chain_up_en) cell_lat_q[i] <= cell_q[i];
    end
  end
  assign chain_latch = cell_lat_q;

  always_comb begin
    case (dr_sel)
      DR_IDENT, DR_USER: dr_so = word_q[0];
      DR_CHAIN:          dr_so = cell_q[0];
      DR_BOOT:           dr_so = boot_sh_q[0];
      default:           dr_so = pass_q;
    endcase
  end
endmodule

// File: rtl/scan_tap_ctrl.sv
module scan_tap_ctrl
  import scan_tap_pkg::*;
#(
  parameter int          NPIN       = 4,
  parameter int          BOOT_W     = 22,
  parameter logic [31:0] ID_VALUE   = 32'h1234_50DD,
  parameter logic [31:0] USER_VALUE = 32'hCAFE_0001
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tms,
  input  logic              tdi,
  output logic              tdo,
  output logic              tdo_oe,
  input  logic [NPIN-1:0]   core_out,
  input  logic [NPIN-1:0]   core_oe,
  input  logic [NPIN-1:0]   pin_in,
  output logic [NPIN-1:0]   pin_out,
  output logic [NPIN-1:0]   pin_oe,
  output logic              hiz_o,
  output logic              clamp_o,
  output logic              reconfig_req,
  output logic [BOOT_W-1:0] boot_addr
);
  logic            rst_n;
  tap_state_t      tap_st;
  logic [IR_W-1:0] ir_act;
  logic            ir_so, dr_so;
  dr_sel_t         dr_sel;
  logic            float_pins, hold_pins, chain_drive, reconf_sel;
  logic [NPIN-1:0] chain_latch;

  scan_rst_sync #(.STAGES(2)) u_rst (.tck(tck), .trst_n(trst_n), .rst_n(rst_n));

  scan_tap_fsm u_fsm (.tck(tck), .rst_n(rst_n), .tms(tms), .state(tap_st));

  scan_tap_ireg u_ir (
    .tck(tck), .rst_n(rst_n), .state(tap_st), .tdi(tdi),
    .ir_act(ir_act), .ir_so(ir_so), .dr_sel(dr_sel),
    .float_pins(float_pins), .hold_pins(hold_pins),
    .chain_drive(chain_drive), .reconf_sel(reconf_sel)
  );

  scan_tap_dregs #(
    .NPIN(NPIN), .WORD_W(32), .BOOT_W(BOOT_W),
    .ID_VALUE(ID_VALUE), .USER_VALUE(USER_VALUE)
  ) u_dr (
    .tck(tck), .rst_n(rst_n), .state(tap_st), .dr_sel(dr_sel), .tdi(tdi),
    .pin_in(pin_in), .dr_so(dr_so), .chain_latch(chain_latch),
    .boot_addr(boot_addr)
  );

  // serial output stage on the falling edge
  logic tdo_q, tdo_d, oe_q, oe_d;
  assign oe_d  = (tap_st == S_SH_IR) || (tap_st == S_SH_DR);
  assign tdo_d = (tap_st == S_SH_IR) ? ir_so : dr_so;
  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      tdo_q <= tdo_d;
      oe_q  <= oe_d;
    end
  end
  assign tdo    = tdo_q;
  assign tdo_oe = oe_q;

  // pin override
  assign pin_out      = chain_drive ? chain_latch : core_out;
  assign pin_oe       = float_pins ? '0 : (chain_drive ? '1 : core_oe);
  assign hiz_o        = float_pins;
  assign clamp_o      = hold_pins;
  assign reconfig_req = reconf_sel && (tap_st == S_RTI);
endmodule

// File: rtl/scan_tap_checker.sv
module scan_tap_checker
  import scan_tap_pkg::*;
#(
  parameter int NPIN   = 4,
  parameter int BOOT_W = 22
) (
  input logic              tck,
  input logic              rst_n,
  input tap_state_t        st,
  input logic [IR_W-1:0]   ir_act,
  input logic              tdo_oe,
  input logic              hiz_o,
  input logic [NPIN-1:0]   pin_oe,
  input logic [BOOT_W-1:0] boot_addr
);
  assert_oe_shift_only_R11: assert property (@(posedge tck) disable iff (!rst_n)
    tdo_oe |-> (st == S_SH_DR || st == S_SH_IR));

  assert_reset_loads_ident_R1: assert property (@(posedge tck) disable iff (!rst_n)
    (st == S_TLR) |=> (ir_act == OP_IDENT));

  assert_ir_moves_on_update_R2: assert property (@(posedge tck) disable iff (!rst_n)
    !$stable(ir_act) |-> (st == S_UPD_IR || st == S_TLR));

  assert_float_clears_oe_R7: assert property (@(posedge tck) disable iff (!rst_n)
    hiz_o |-> (pin_oe == '0));

  assert_boot_moves_on_update_R9: assert property (@(posedge tck) disable iff (!rst_n)
    !$stable(boot_addr) |-> (st == S_UPD_DR));
endmodule

bind scan_tap_ctrl scan_tap_checker #(.NPIN(NPIN), .BOOT_W(BOOT_W)) u_chk (
  .tck(tck), .rst_n(rst_n), .st(tap_st), .ir_act(ir_act),
  .tdo_oe(tdo_oe), .hiz_o(hiz_o), .pin_oe(pin_oe), .boot_addr(boot_addr)
);

// File: tb/scan_tap_ctrl_bench.sv
module scan_tap_ctrl_bench;
  localparam int          NPIN   = 4;
  localparam int          BOOT_W = 22;
  localparam logic [31:0] IDW    = 32'h1234_50DD;
  localparam logic [31:0] USRW   = 32'hCAFE_0001;

  logic              tck, trst_n, tms, tdi;
  logic              tdo, tdo_oe, hiz_o, clamp_o, reconfig_req;
  logic [NPIN-1:0]   core_out, core_oe, pin_in, pin_out, pin_oe;
  logic [BOOT_W-1:0] boot_addr;

  int n_chk = 0;
  int n_err = 0;

  scan_tap_ctrl #(.NPIN(NPIN), .BOOT_W(BOOT_W), .ID_VALUE(IDW), .USER_VALUE(USRW)) u_scan_tap_ctrl (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .core_out(core_out), .core_oe(core_oe), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .hiz_o(hiz_o), .clamp_o(clamp_o),
    .reconfig_req(reconfig_req), .boot_addr(boot_addr)
  );

  initial tck = 1'b0;
  always #2 tck = ~tck;

  typedef struct packed {
    logic [3:0]  req;
    logic [9:0]  op;
    logic [6:0]  len;
    logic [31:0] din;
    logic [31:0] exp;
  } vec_t;

  // R3 words, R4 pass-through, R7/R8 through pass stage, R9 boot capture
  localparam vec_t VECS [8] = '{
    '{4'd3, 10'h006, 7'd32, 32'h0000_0000, IDW},
    '{4'd3, 10'h007, 7'd32, 32'hFFFF_FFFF, USRW},
    '{4'd4, 10'h3FF, 7'd8,  32'h0000_00A5, 32'h0000_004A},
    '{4'd4, 10'h155, 7'd8,  32'h0000_003C, 32'h0000_0078},
    '{4'd7, 10'h00B, 7'd8,  32'h0000_0081, 32'h0000_0002},
    '{4'd8, 10'h00A, 7'd8,  32'h0000_00F0, 32'h0000_00E0},
    '{4'd9, 10'h270, 7'd22, 32'h002A_5A5A, 32'h0000_0000},
    '{4'd9, 10'h270, 7'd22, 32'h0015_A5A5, 32'h002A_5A5A}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d, output logic o);
    o   = tdo;
    tms = m;
    tdi = d;
    @(posedge tck);
    @(negedge tck);
    #1;
  endtask

  task automatic shift_ir(input logic [9:0] op, output logic [9:0] cap);
    logic o;
    step(1, 0, o); step(1, 0, o); step(0, 0, o); step(0, 0, o);
    for (int i = 0; i < 10; i++) begin
      step(i == 9, op[i], o);
      cap[i] = o;
    end
    step(1, 0, o); step(0, 0, o);
  endtask

  task automatic shift_dr(input logic [31:0] din, input int n, output logic [31:0] dout);
    logic o;
    dout = '0;
    step(1, 0, o); step(0, 0, o); step(0, 0, o);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i], o);
      dout[i] = o;
    end
    step(1, 0, o); step(0, 0, o);
  endtask

  initial begin
    repeat (100000) @(posedge tck);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [9:0]  cap;
    logic [31:0] dout, msk;
    logic        o;
    trst_n = 0; tms = 1; tdi = 0;
    core_out = 4'b0011; core_oe = 4'b0101; pin_in = 4'b1010;
    repeat (3) @(negedge tck);
    #1;
    trst_n = 1;
    // reset state (R1, R11, R10, R9)
    chk("R11 reset oe", {31'd0, tdo_oe}, 32'd0);
    chk("R10 reset req", {31'd0, reconfig_req}, 32'd0);
    chk("R9 reset boot", {10'd0, boot_addr}, 32'd0);
    chk("R5 reset pins", {24'd0, pin_oe, pin_out}, {24'd0, core_oe, core_out});
    repeat (4) step(0, 0, o);
    shift_dr(32'd0, 32, dout);
    chk("R1 default ident", dout, IDW);

    // vector walk
    foreach (VECS[k]) begin
      shift_ir(VECS[k].op, cap);
      chk("R2 capture-ir", {22'd0, cap}, {22'd0, 10'h001});
      shift_dr(VECS[k].din, int'(VECS[k].len), dout);
      msk = (VECS[k].len == 7'd32) ? 32'hFFFF_FFFF : ((32'd1 << VECS[k].len) - 32'd1);
      chk($sformatf("R%0d vector %0d", VECS[k].req, k), dout & msk, VECS[k].exp);
    end
    chk("R9 boot latched", {10'd0, boot_addr}, 32'h0015_A5A5);

    // boundary sequence R5 R6 R8 R7
    shift_ir(10'h005, cap);
    shift_dr(32'h6, 4, dout);
    chk("R5 sample capture", dout & 32'hF, 32'hA);
    chk("R5 pins untouched", {24'd0, pin_oe, pin_out}, {24'd0, 4'b0101, 4'b0011});
    shift_ir(10'h00F, cap);
    chk("R6 extest pins", {24'd0, pin_oe, pin_out}, {24'd0, 4'b1111, 4'b0110});
    shift_dr(32'h9, 4, dout);
    chk("R6 extest capture", dout & 32'hF, 32'hA);
    chk("R6 extest update", {28'd0, pin_out}, 32'h9);
    shift_ir(10'h00A, cap);
    chk("R8 clamp pins", {23'd0, clamp_o, pin_oe, pin_out}, {23'd0, 1'b1, 4'b1111, 4'b1001});
    shift_dr(32'hA5, 8, dout);
    chk("R8 clamp keeps latch", {28'd0, pin_out}, 32'h9);
    shift_ir(10'h00B, cap);
    chk("R7 float pins", {27'd0, hiz_o, pin_oe}, {27'd0, 1'b1, 4'b0000});

    // R2: instruction unchanged until Update-IR
    step(1, 0, o); step(1, 0, o); step(0, 0, o); step(0, 0, o);
    for (int i = 0; i < 10; i++) step(i == 9, 1'b1, o);
    chk("R2 no effect before update", {31'd0, hiz_o}, 32'd1);
    step(1, 0, o);
    chk("R2 effect at update", {27'd0, hiz_o, pin_oe}, {27'd0, 1'b0, 4'b0101});
    step(0, 0, o);

    // R10 reconfiguration request, then R1 via mode-select
    shift_ir(10'h007, cap);
    shift_ir(10'h001, cap);
    chk("R10 req in idle", {31'd0, reconfig_req}, 32'd1);
    step(1, 0, o);
    chk("R10 req off idle", {31'd0, reconfig_req}, 32'd0);
    repeat (5) step(1, 0, o);
    step(0, 0, o);
    chk("R10 req after reset", {31'd0, reconfig_req}, 32'd0);
    shift_dr(32'd0, 32, dout);
    chk("R1 five tms ones", dout, IDW);

    // R11 output enable and falling-edge timing
    chk("R11 oe idle", {31'd0, tdo_oe}, 32'd0);
    step(1, 0, o); step(0, 0, o); step(0, 0, o);
    chk("R11 oe shift", {31'd0, tdo_oe}, 32'd1);
    chk("R11 first bit", {31'd0, tdo}, {31'd0, IDW[0]});
    tms = 0; tdi = 0;
    @(posedge tck); #1;
    chk("R11 holds after rise", {31'd0, tdo}, {31'd0, IDW[0]});
    @(negedge tck); #1;
    chk("R11 moves at fall", {31'd0, tdo}, {31'd0, IDW[1]});
    step(1, 0, o); step(1, 0, o); step(0, 0, o);
    chk("R11 oe off", {31'd0, tdo_oe}, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule